// File: doc/BRIEF.md
# Processor Exception Entry Unit

This block performs the state transition a 64-bit processor makes when it takes an exception. Each cycle it can receive one request, raised as a single bit in a ten-bit one-hot cause vector. The request comes with the current instruction address, the current machine state word, a faulting effective address, a three-bit reason code and a store flag. When it accepts a request, it commits all of its outputs in that cycle as one update. These outputs are the saved return address, the saved machine state, the new machine state, the fault address and fault syndrome registers, and the fetch address of the handler.

Bit positions use big-endian numbering: architectural bit k of a 64-bit word is SystemVerilog bit 63-k. Two causes are asynchronous and maskable, external and decrementer. They are taken only while the interrupt-enable bit is set. When it is clear, the unit raises a not-delivered pulse and leaves every register unchanged. The unit also flags two conditions: entry while the recoverable bit is already clear, and a reason code it does not recognise.

Cause indices are: 0 machine check, 1 data storage, 2 instruction storage, 3 external, 4 alignment, 5 program, 6 FP unavailable, 7 decrementer, 8 system call, 9 FP assist.

Top module: `exc_entry_unit`

## Requirements
- R1: After reset, every data output is zero and `ack_o`, `nodeliver_o`, `unrecov_o` and `badreason_o` are low.
- R2: On an accepted request, `msr_o` equals the old state with SV bits 18, 15, 14, 13, 11, 10, 9, 8, 5, 4 and 1 cleared (mask 0x0004_EF32) and bit 63 (64-bit mode) forced to 1. All other bits keep their old values.
- R3: On an accepted request, `srr1_o` keeps only the old state bits in mask 0xFFFF_FFFF_87C0_FFFF. For causes other than instruction storage and program, nothing else changes.
- R4: On an accepted request, `srr0_o` equals the request address. For a system call it equals that address plus 4.
- R5: `nia_o` equals base plus offset. The base is 0xFFFF_FFFF_FFF0_0000 when bit 6 of the new state is set, and zero otherwise.
- R6: The offsets by cause index 0..9 are 0x200, 0x300, 0x400, 0x500, 0x600, 0x700, 0x800, 0x900, 0xC00 and 0xE00.
- R7: An external or decrementer request with state bit 15 clear gives a one-cycle `nodeliver_o` pulse and no `ack_o`, and leaves all output registers unchanged.
- R8: On a data storage request, `dar_o` takes the effective address. `dsisr_o` takes one reason bit, given here as reason code then DSISR SV bit: 0→31, 1→30, 2→27, 3→21, 4→26, 5→20. Bit 25 is ORed in when the store flag is set.
- R9: On an instruction storage request, SRR1 architectural bits 1–4 and 10–14 (mask 0x783E_0000_0000_0000) are cleared first. Then one reason bit is set, given as reason code then SV bit: 0→60, 1→62, 2→59, 3→53. `dar_o` and `dsisr_o` do not change.
- R10: On a program request, the same SRR1 field is cleared, and the reason codes set SV bits as follows: 0→51 (illegal), 1→50 (privileged), 2→49 (trap).
- R11: On an alignment request, `dar_o` takes the effective address and `dsisr_o` becomes zero.
- R12: `unrecov_o` pulses together with `ack_o` when the old state bit 1 (recoverable) was clear.
- R13: A reason code the cause does not define contributes no reason bits. Such codes are data storage 6–7, instruction storage 4–7 and program 3–7. The update still commits, and `badreason_o` pulses with `ack_o`.
- R14: `ack_o` is high for exactly the cycle after an accepting edge. A request vector with zero bits or with more than one bit set is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 10 | One-hot cause request |
| cia_i | input | 64 | Address of the current instruction |
| msr_i | input | 64 | Current machine state |
| ea_i | input | 64 | Faulting effective address |
| reason_i | input | 3 | Cause-specific reason code |
| store_i | input | 1 | Faulting access was a store |
| srr0_o | output | 64 | Saved return address |
| srr1_o | output | 64 | Saved machine state with reason bits |
| msr_o | output | 64 | New machine state |
| dar_o | output | 64 | Fault address register |
| dsisr_o | output | 32 | Fault syndrome register |
| nia_o | output | 64 | Handler fetch address |
| ack_o | output | 1 | Request committed last edge |
| nodeliver_o | output | 1 | Masked request refused last edge |
| unrecov_o | output | 1 | Entry taken with recoverable bit clear |
| badreason_o | output | 1 | Unknown reason code on committed entry |

## Verification
Every cycle, the assertions check that accept and refuse are mutually exclusive, and that a refusal leaves every register stable. On each commit they also check that the new state has 64-bit mode set with enable and recoverable cleared, that the handler address is aligned to 256 bytes, and that the two flags never appear without an acknowledge. Only the bench's sweep shows the exact values. That sweep covers every cause, reason code and store flag, under four state words chosen to toggle the enable, recoverable and prefix bits. The values it checks are the masked SRR1 image, each syndrome encoding, the system call's return address and the high vector base.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
  localparam int XLEN    = 64;
  localparam int SYN_W   = 32;
  localparam int NCAUSE  = 10;
  localparam int RSN_W   = 3;
  localparam int IDX_W   = $clog2(NCAUSE);
  localparam int OFF_W   = 12;

  // cause indices within the request vector
  localparam int C_MCHK  = 0;
  localparam int C_DSTOR = 1;
  localparam int C_ISTOR = 2;
  localparam int C_EXT   = 3;
  localparam int C_ALIGN = 4;
  localparam int C_PROG  = 5;
  localparam int C_FPUN  = 6;
  localparam int C_DEC   = 7;
  localparam int C_SCALL = 8;
  localparam int C_FPAS  = 9;

  // state-word bit positions (SV numbering)
  localparam int ST_WIDE = 63;
  localparam int ST_EE   = 15;
  localparam int ST_RI   = 1;
  localparam int ST_IP   = 6;

  localparam logic [XLEN-1:0] ST_ENTRY_CLR  = 64'h0000_0000_0004_EF32;
  localparam logic [XLEN-1:0] SAVE_KEEP     = 64'hFFFF_FFFF_87C0_FFFF;
  localparam logic [XLEN-1:0] SAVE_RSN_FLD  = 64'h783E_0000_0000_0000;
  localparam logic [XLEN-1:0] VEC_HI_BASE   = 64'hFFFF_FFFF_FFF0_0000;

  // architectural (MSB-first) bit k to a one-hot SV word
  function automatic logic [XLEN-1:0] abit64(input int k);
    return {{(XLEN-1){1'b0}}, 1'b1} << (XLEN - 1 - k);
  endfunction

  function automatic logic [SYN_W-1:0] abit32(input int k);
    return {{(SYN_W-1){1'b0}}, 1'b1} << (SYN_W - 1 - k);
  endfunction

  function automatic logic [OFF_W-1:0] vec_offset(input logic [IDX_W-1:0] idx);
    case (idx)
      4'd0:    return 12'h200;
      4'd1:    return 12'h300;
      4'd2:    return 12'h400;
      4'd3:    return 12'h500;
      4'd4:    return 12'h600;
      4'd5:    return 12'h700;
      4'd6:    return 12'h800;
      4'd7:    return 12'h900;
      4'd8:    return 12'hC00;
      4'd9:    return 12'hE00;
      default: return 12'h000;
    endcase
  endfunction

  function automatic logic [IDX_W-1:0] onehot_index(input logic [NCAUSE-1:0] v);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = 0; i < NCAUSE; i++)
      if (v[i]) r = r | i[IDX_W-1:0];
    return r;
  endfunction
endpackage

// File: rtl/exc_state_calc.sv
module exc_state_calc
  import exc_entry_pkg::*;
(
  input  logic [XLEN-1:0] st_old,
  input  logic [XLEN-1:0] save_clr,
  input  logic [XLEN-1:0] save_set,
  output logic [XLEN-1:0] st_new,
  output logic [XLEN-1:0] save_new
);
  always_comb begin
    st_new   = (st_old & ~ST_ENTRY_CLR) | abit64(0);
    save_new = (st_old & SAVE_KEEP & ~save_clr) | save_set;
  end
endmodule

// File: rtl/exc_syndrome.sv
module exc_syndrome
  import exc_entry_pkg::*;
(
  input  logic [IDX_W-1:0] idx,
  input  logic [RSN_W-1:0] reason,
  input  logic             is_store,
  output logic [XLEN-1:0]  save_set,
  output logic [XLEN-1:0]  save_clr,
  output logic [SYN_W-1:0] syn_val,
  output logic             fault_wr,
  output logic             bad
);
  always_comb begin
    save_set = '0;
    save_clr = '0;
    syn_val  = '0;
    fault_wr = 1'b0;
    bad      = 1'b0;
    case (int'(idx))
      C_DSTOR: begin
        fault_wr = 1'b1;
        case (reason)
          3'd0:    syn_val = abit32(0);
          3'd1:    syn_val = abit32(1);
          3'd2:    syn_val = abit32(4);
          3'd3:    syn_val = abit32(10);
          3'd4:    syn_val = abit32(5);
          3'd5:    syn_val = abit32(11);
          default: bad     = 1'b1;
        endcase
        if (is_store) syn_val = syn_val | abit32(6);
      end
      C_ISTOR: begin
        save_clr = SAVE_RSN_FLD;
        case (reason)
          3'd0:    save_set = abit64(3);
          3'd1:    save_set = abit64(1);
          3'd2:    save_set = abit64(4);
          3'd3:    save_set = abit64(10);
          default: bad      = 1'b1;
        endcase
      end
      C_PROG: begin
        save_clr = SAVE_RSN_FLD;
        case (reason)
          3'd0:    save_set = abit64(12);
          3'd1:    save_set = abit64(13);
          3'd2:    save_set = abit64(14);
          default: bad      = 1'b1;
        endcase
      end
      C_ALIGN: fault_wr = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/exc_vector_gen.sv
module exc_vector_gen
  import exc_entry_pkg::*;
(
  input  logic [IDX_W-1:0] idx,
  input  logic             hi_prefix,
  output logic [XLEN-1:0]  nia
);
  logic [XLEN-1:0] base;
  always_comb begin
    base = hi_prefix ? VEC_HI_BASE : '0;
    nia  = base + {{(XLEN-OFF_W){1'b0}}, vec_offset(idx)};
  end
endmodule

// File: rtl/exc_entry_unit.sv
module exc_entry_unit
  import exc_entry_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCAUSE-1:0] req_i,
  input  logic [XLEN-1:0]   cia_i,
  input  logic [XLEN-1:0]   msr_i,
  input  logic [XLEN-1:0]   ea_i,
  input  logic [RSN_W-1:0]  reason_i,
  input  logic              store_i,
  output logic [XLEN-1:0]   srr0_o,
  output logic [XLEN-1:0]   srr1_o,
  output logic [XLEN-1:0]   msr_o,
  output logic [XLEN-1:0]   dar_o,
  output logic [SYN_W-1:0]  dsisr_o,
  output logic [XLEN-1:0]   nia_o,
  output logic              ack_o,
  output logic              nodeliver_o,
  output logic              unrecov_o,
  output logic              badreason_o
);
  logic             single, maskable, take, drop;
  logic [IDX_W-1:0] idx;
  logic [XLEN-1:0]  save_set, save_clr, st_new, save_new, nia_new, ret_addr;
  logic [SYN_W-1:0] syn_val;
  logic             fault_wr, bad;

  always_comb begin
    single   = $onehot(req_i);
    idx      = onehot_index(req_i);
    maskable = req_i[C_EXT] | req_i[C_DEC];
    take     = single & ~(maskable & ~msr_i[ST_EE]);
    drop     = single & maskable & ~msr_i[ST_EE];
    ret_addr = req_i[C_SCALL] ? cia_i + 64'd4 : cia_i;
  end

  exc_syndrome u_syn (
    .idx(idx), .reason(reason_i), .is_store(store_i),
    .save_set(save_set), .save_clr(save_clr), .syn_val(syn_val),
    .fault_wr(fault_wr), .bad(bad)
  );

  exc_state_calc u_state (
    .st_old(msr_i), .save_clr(save_clr), .save_set(save_set),
    .st_new(st_new), .save_new(save_new)
  );

  exc_vector_gen u_vec (
    .idx(idx), .hi_prefix(st_new[ST_IP]), .nia(nia_new)
  );

  // next-state
  logic [XLEN-1:0]  srr0_d, srr1_d, msr_d, dar_d, nia_d;
  logic [SYN_W-1:0] dsisr_d;
  always_comb begin
    srr0_d  = srr0_o;
    srr1_d  = srr1_o;
    msr_d   = msr_o;
    nia_d   = nia_o;
    dar_d   = dar_o;
    dsisr_d = dsisr_o;
    if (take) begin
      srr0_d = ret_addr;
      srr1_d = save_new;
      msr_d  = st_new;
      nia_d  = nia_new;
      if (fault_wr) begin
        dar_d   = ea_i;
        dsisr_d = syn_val;
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      srr0_o      <= '0;
      srr1_o      <= '0;
      msr_o       <= '0;
      dar_o       <= '0;
      dsisr_o     <= '0;
      nia_o       <= '0;
      ack_o       <= 1'b0;
      nodeliver_o <= 1'b0;
      unrecov_o   <= 1'b0;
      badreason_o <= 1'b0;
    end else begin
      srr0_o      <= srr0_d;
      srr1_o      <= srr1_d;
      msr_o       <= msr_d;
      dar_o       <= dar_d;
      dsisr_o     <= dsisr_d;
      nia_o       <= nia_d;
      ack_o       <= take;
      nodeliver_o <= drop;
      unrecov_o   <= take & ~msr_i[ST_RI];
      badreason_o <= take & bad;
    end
  end

  assert_accept_refuse_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(ack_o && nodeliver_o));
  assert_refuse_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    nodeliver_o |-> ($stable(msr_o) && $stable(srr0_o) && $stable(srr1_o)
                     && $stable(nia_o) && $stable(dar_o) && $stable(dsisr_o)));
  assert_entry_state_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o |-> (msr_o[ST_WIDE] && !msr_o[ST_EE] && !msr_o[ST_RI]));
  assert_vector_aligned_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o |-> (nia_o[7:0] == 8'h00));
  assert_unrecov_needs_ack_R12: assert property (@(posedge clk) disable iff (!rst_n)
    unrecov_o |-> ack_o);
  assert_bad_needs_ack_R13: assert property (@(posedge clk) disable iff (!rst_n)
    badreason_o |-> ack_o);
  assert_ack_from_request_R14: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o |-> $past(req_i != '0));
endmodule

// File: tb/sim_exc_entry_unit.sv
module sim_exc_entry_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [9:0]  req;
  logic [63:0] cia, msr, ea;
  logic [2:0]  reason;
  logic        store;
  logic [63:0] srr0, srr1, msr_n, dar, nia;
  logic [31:0] dsisr;
  logic        ack, nodel, unrec, badr;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  exc_entry_unit u0 (
    .clk(clk), .rst_n(rst_n), .req_i(req), .cia_i(cia), .msr_i(msr),
    .ea_i(ea), .reason_i(reason), .store_i(store),
    .srr0_o(srr0), .srr1_o(srr1), .msr_o(msr_n), .dar_o(dar),
    .dsisr_o(dsisr), .nia_o(nia), .ack_o(ack), .nodeliver_o(nodel),
    .unrecov_o(unrec), .badreason_o(badr)
  );

  function automatic logic [63:0] ib(input int k);
    return 64'd1 << (63 - k);
  endfunction
  function automatic logic [31:0] db(input int k);
    return 32'd1 << (31 - k);
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  logic [63:0] e_srr0, e_srr1, e_msr, e_dar, e_nia;
  logic [31:0] e_dsisr;

  task automatic check_regs(input string t_sr1, input string t_fault, input string t_nia);
    chk("R4", srr0, e_srr0);
    chk(t_sr1, srr1, e_srr1);
    chk("R2", msr_n, e_msr);
    chk(t_fault, dar, e_dar);
    chk(t_fault, {32'd0, dsisr}, {32'd0, e_dsisr});
    chk(t_nia, nia, e_nia);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R14 watchdog actual running expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [63:0] pats [4];
    logic [63:0] entry_clr, keep, fld;
    logic [11:0] offs [10];
    pats[0] = 64'hFFFF_FFFF_FFFF_FFFF;
    pats[1] = 64'h0000_0000_0000_0000;
    pats[2] = 64'hA5A5_A5A5_A5A5_A5A5;
    pats[3] = 64'h5A5A_5A5A_5A5A_5A5A;
    offs[0] = 12'h200; offs[1] = 12'h300; offs[2] = 12'h400; offs[3] = 12'h500;
    offs[4] = 12'h600; offs[5] = 12'h700; offs[6] = 12'h800; offs[7] = 12'h900;
    offs[8] = 12'hC00; offs[9] = 12'hE00;
    entry_clr = ib(54) | ib(59) | ib(48) | ib(52) | ib(55) | ib(50)
              | ib(58) | ib(45) | ib(49) | ib(62) | ib(53);
    keep = '0;
    for (int k = 0; k < 64; k++)
      if (k <= 32 || (k >= 37 && k <= 41) || k >= 48) keep |= ib(k);
    fld = '0;
    for (int k = 1; k <= 14; k++)
      if (k <= 4 || k >= 10) fld |= ib(k);

    rst_n = 1'b0; req = '0; cia = '0; msr = '0; ea = '0; reason = '0; store = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    e_srr0 = '0; e_srr1 = '0; e_msr = '0; e_dar = '0; e_dsisr = '0; e_nia = '0;
    check_regs("R1", "R1", "R1");
    chk("R1", {60'd0, ack, nodel, unrec, badr}, 64'd0);

    for (int m = 0; m < 4; m++)
      for (int c = 0; c < 10; c++)
        for (int r = 0; r < 8; r++)
          for (int s = 0; s < 2; s++) begin
            logic [63:0] old, nm, sset, sclr;
            logic [31:0] syn;
            logic acc, badx, fw;
            old = pats[m];
            req = 10'd1 << c;
            msr = old;
            cia = 64'h0123_4567_0000_0000 + 64'(((m * 10 + c) * 16 + r * 2 + s) * 4);
            ea  = ~cia ^ 64'h0000_00F0_0F00_0003;
            reason = 3'(r);
            store = s[0];
            @(negedge clk);
            acc = !((c == 3 || c == 7) && !old[15]);
            badx = (c == 1 && r > 5) || (c == 2 && r > 3) || (c == 5 && r > 2);
            if (acc) begin
              nm = (old & ~entry_clr) | ib(0);
              sset = '0; sclr = '0; syn = '0; fw = 1'b0;
              if (c == 2) begin
                sclr = fld;
                if (r == 0) sset = ib(3);
                if (r == 1) sset = ib(1);
                if (r == 2) sset = ib(4);
                if (r == 3) sset = ib(10);
              end
              if (c == 5) begin
                sclr = fld;
                if (r < 3) sset = ib(12 + r);
              end
              if (c == 1) begin
                fw = 1'b1;
                if (r == 0) syn = db(0);
                if (r == 1) syn = db(1);
                if (r == 2) syn = db(4);
                if (r == 3) syn = db(10);
                if (r == 4) syn = db(5);
                if (r == 5) syn = db(11);
                if (s == 1) syn |= db(6);
              end
              if (c == 4) fw = 1'b1;
              e_srr0 = (c == 8) ? cia + 64'd4 : cia;
              e_srr1 = (old & keep & ~sclr) | sset;
              e_msr  = nm;
              e_nia  = (nm[6] ? 64'hFFFF_FFFF_FFF0_0000 : 64'd0) + {52'd0, offs[c]};
              if (fw) begin e_dar = ea; e_dsisr = syn; end
            end
            check_regs(c == 2 ? "R9" : (c == 5 ? "R10" : "R3"),
                       c == 1 ? "R8" : (c == 4 ? "R11" : "R9"),
                       e_nia[63] ? "R5" : "R6");
            chk("R7", {63'd0, nodel}, {63'd0, !acc});
            chk("R14", {63'd0, ack}, {63'd0, acc});
            chk("R12", {63'd0, unrec}, {63'd0, acc && !old[1]});
            chk("R13", {63'd0, badr}, {63'd0, acc && badx});
            req = '0;
          end

    // R14: idle cycle yields no acknowledge
    @(negedge clk);
    chk("R14", {62'd0, ack, nodel}, 64'd0);
    // R14: multi-hot request is ignored
    req = 10'b00_0001_0001; msr = '1; cia = 64'h55; ea = 64'h66;
    @(negedge clk);
    chk("R14", {62'd0, ack, nodel}, 64'd0);
    check_regs("R14", "R14", "R14");
    req = '0;
    @(negedge clk);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule